// File: doc/BRIEF.md
# Programmable Down-Counter / Square-Wave Divider

This block holds a 16-bit down-counter that works in one of two modes, chosen by a static mode input. As a divider it produces a continuous square wave whose half-period is the loaded preload value, counted in enabled clock cycles. As an event counter it counts enabled cycles down from the preload once, raises a ready flag and drops its output at zero, then keeps counting through the wrap until software halts it.

Software supplies the preload through two byte-wide write strobes, one for the high byte and one for the low byte. The preload registers cannot be read back. Single-cycle start and stop strobes control the run. A count-enable input marks the cycles that advance the counter, so the block is independent of any clock-source choice. In counter mode the live count can be read as two bytes.

Top module: `ctmr_top`

## Requirements
- R1: After reset the wave output is 1, ready is 0 and the count readback is 0. Before the first start, enabled cycles change none of these.
- R2: A pulse on wr_hi loads wr_data into preload bits 15:8, and a pulse on wr_lo loads wr_data into bits 7:0. Reset leaves the preload at 0x0002. A start copies the preload into the counter.
- R3: Mode 0 selects the divider. After a start the wave output is 1 and toggles after every P enabled cycles, where P is the preload, giving a period of 2P.
- R4: In mode 0, ready goes to 1 only when the wave output toggles from 0 to 1, so once per full period.
- R5: In mode 0 a stop pulse clears ready and nothing else. The wave keeps toggling, and ready sets again at the next full period.
- R6: In mode 0 a preload written during a half-period leaves that half-period at its old length. The following half-periods use the new value.
- R7: A start while running abandons the current half-period, drives the wave to 1 and begins a fresh half-period of P enabled cycles.
- R8: Mode 1 selects the counter. Each enabled cycle after a start decrements the count. When the count reaches 0x0000, ready goes to 1 and the wave output goes to 0.
- R9: In mode 1 the count wraps from 0x0000 to 0xFFFF and keeps decrementing. The wave stays 0.
- R10: In mode 1 a stop pulse halts the count at its current value, returns the wave to 1 and clears ready.
- R11: In mode 1 a preload written during a count does not change the running count. The next start loads the latest preload, and with no new write a start reuses the previous preload.
- R12: Cycles with cnt_en at 0 never change the count or the wave.
- R13: In mode 1, cnt_hi and cnt_lo show the live count bits 15:8 and 7:0. In mode 0 both read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | 0 = divider, 1 = one-shot counter |
| cnt_en | input | 1 | Count enable, one decrement per high cycle |
| wr_hi | input | 1 | Write strobe for preload high byte |
| wr_lo | input | 1 | Write strobe for preload low byte |
| wr_data | input | 8 | Byte written by wr_hi or wr_lo |
| start | input | 1 | Start / restart strobe |
| stop | input | 1 | Stop strobe |
| wave_out | output | 1 | Square wave (mode 0) or count output (mode 1) |
| ready | output | 1 | Ready status flag |
| cnt_hi | output | 8 | Live count high byte (mode 1) |
| cnt_lo | output | 8 | Live count low byte (mode 1) |

## Verification
The divider runs with a small preload of 3 and then has a 5 written into it mid-half-period. This shows whether the reload uses the live preload at each zero or a stale copy, and the counts before each toggle show whether the length is off by one. A restart while the wave is low separates a counter that reloads from one that only resumes. The counter runs across zero into the wrap, then stops, and then restarts with and without a fresh preload write. These runs tell apart stop-halts from stop-clears-only, and tell a start-time load from a continuous load. Stretches of idle cnt_en cycles between the steps show whether the decrement follows the enable or the clock.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int unsigned CT_DEFAULT_W = 16;

  localparam logic MODE_TIMER = 1'b0;
  localparam logic MODE_COUNT = 1'b1;

  // Wrapping decrement within a w-bit field (w <= 32).
  function automatic logic [31:0] ct_wrap_dec(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v - 32'd1) & mask;
  endfunction

  // The step that leaves the counter at zero starts from one.
  function automatic logic ct_at_one(input logic [31:0] v);
    return (v == 32'd1);
  endfunction

endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  parameter logic [LANES*LANE_W-1:0] RESET_VAL = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANE_W-1:0]         lane_data,
  output logic [LANES*LANE_W-1:0]   value
);

  // One write-only byte lane per generate iteration.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= RESET_VAL[g*LANE_W +: LANE_W];
      end else if (lane_we[g]) begin
        lane_q <= lane_data;
      end
    end

    assign value[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int unsigned WIDTH = CT_DEFAULT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [WIDTH-1:0] preload,
  output logic [WIDTH-1:0] count,
  output logic             running,
  output logic             ev_reload,
  output logic             ev_terminal
);

  logic             at_one;
  logic             halt_req;
  logic             step;
  logic [WIDTH-1:0] dec_val;
  logic [WIDTH-1:0] nxt_val;

  assign at_one   = ct_at_one(32'(count));
  assign dec_val  = WIDTH'(ct_wrap_dec(32'(count), WIDTH));

  // Stop halts the count only in counter mode; start outranks it.
  assign halt_req = stop && (mode == MODE_COUNT);
  assign step     = running && tick && !start && !halt_req;

  assign ev_reload   = step && (mode == MODE_TIMER) && at_one;
  assign ev_terminal = step && (mode == MODE_COUNT) && at_one;

  // Divider reloads from the live preload; counter just wraps.
  assign nxt_val = ev_reload ? preload : dec_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (start) begin
      count   <= preload;
      running <= 1'b1;
    end else if (halt_req) begin
      running <= 1'b0;
    end else if (step) begin
      count   <= nxt_val;
    end
  end

endmodule

// File: rtl/ctmr_status.sv
module ctmr_status
  import ctmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic start,
  input  logic stop,
  input  logic ev_reload,
  input  logic ev_terminal,
  output logic wave_out,
  output logic ready,
  output logic ev_full
);

  logic ready_set;
  logic wave_high_req;

  // A full divider period ends when the wave rises.
  assign ev_full       = ev_reload && !wave_out;
  assign ready_set     = ev_full || ev_terminal;
  assign wave_high_req = start || (stop && (mode == MODE_COUNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_out <= 1'b1;
    end else if (wave_high_req) begin
      wave_out <= 1'b1;
    end else if (ev_reload) begin
      wave_out <= ~wave_out;
    end else if (ev_terminal) begin
      wave_out <= 1'b0;
    end
  end

  // A set event in the same cycle wins over a stop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
    end else if (ready_set) begin
      ready <= 1'b1;
    end else if (stop) begin
      ready <= 1'b0;
    end
  end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned WIDTH = CT_DEFAULT_W,
  parameter int unsigned HALF  = WIDTH / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic            cnt_en,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [HALF-1:0] wr_data,
  input  logic            start,
  input  logic            stop,
  output logic            wave_out,
  output logic            ready,
  output logic [HALF-1:0] cnt_hi,
  output logic [HALF-1:0] cnt_lo
);

  localparam int unsigned LANES = WIDTH / HALF;

  logic [LANES-1:0] lane_we;
  logic [WIDTH-1:0] preload;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] rd_view;
  logic             core_running;
  logic             ev_reload;
  logic             ev_terminal;
  logic             ev_full;

  assign lane_we = {wr_hi, wr_lo};

  ctmr_preload #(
    .LANE_W    (HALF),
    .LANES     (LANES),
    .RESET_VAL (WIDTH'(2))
  ) u_preload (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .lane_data (wr_data),
    .value     (preload)
  );

  ctmr_core #(
    .WIDTH (WIDTH)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .tick        (cnt_en),
    .start       (start),
    .stop        (stop),
    .preload     (preload),
    .count       (count),
    .running     (core_running),
    .ev_reload   (ev_reload),
    .ev_terminal (ev_terminal)
  );

  ctmr_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .start       (start),
    .stop        (stop),
    .ev_reload   (ev_reload),
    .ev_terminal (ev_terminal),
    .wave_out    (wave_out),
    .ready       (ready),
    .ev_full     (ev_full)
  );

  // Live count is visible only in counter mode.
  assign rd_view = (mode == MODE_COUNT) ? count : '0;
  assign cnt_hi  = rd_view[WIDTH-1:HALF];
  assign cnt_lo  = rd_view[HALF-1:0];

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int unsigned HALF = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode,
  input logic            start,
  input logic            stop,
  input logic            running,
  input logic            ev_reload,
  input logic            ev_terminal,
  input logic            ev_full,
  input logic            wave_out,
  input logic            ready,
  input logic [HALF-1:0] cnt_hi,
  input logic [HALF-1:0] cnt_lo
);

  // R1: no count events while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!ev_reload && !ev_terminal));

  // R3: divider reload toggles the wave
  p_reload_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 1'b0) && ev_reload) |=> (wave_out != $past(wave_out)));

  // R4: a full period leaves ready set
  p_full_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> ready);

  // R5: stop without a set event clears ready
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !ev_full && !ev_terminal) |=> !ready);

  // R8: terminal count drives output low and sets ready
  p_terminal_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_terminal |=> (!wave_out && ready));

  // R10: counter stop halts and returns the output high
  p_count_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 1'b1) && stop && !start) |=> (!running && wave_out));

  // R10: a halted counter holds its readback
  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 1'b1) && !running && !start) |=> ((mode != 1'b1) || $stable({cnt_hi, cnt_lo})));

  // R7: start drives the wave high
  p_start_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> wave_out);

endmodule

bind ctmr_top ctmr_chk #(.HALF(HALF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .start       (start),
  .stop        (stop),
  .running     (core_running),
  .ev_reload   (ev_reload),
  .ev_terminal (ev_terminal),
  .ev_full     (ev_full),
  .wave_out    (wave_out),
  .ready       (ready),
  .cnt_hi      (cnt_hi),
  .cnt_lo      (cnt_lo)
);

// File: tb/tb_ctmr_top.sv
`timescale 1ns/1ps
module tb_ctmr_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic       wave_out;
  logic       ready;
  logic [7:0] cnt_hi;
  logic [7:0] cnt_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctmr_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cnt_en   (cnt_en),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .wr_data  (wr_data),
    .start    (start),
    .stop     (stop),
    .wave_out (wave_out),
    .ready    (ready),
    .cnt_hi   (cnt_hi),
    .cnt_lo   (cnt_lo)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic set_preload(input logic [15:0] v);
    @(negedge clk);
    wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0];
    @(negedge clk);
    wr_lo = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 wave after reset", wave_out, 1);
    check("R1 ready after reset", ready, 0);
    check("R1 readback after reset", rd(), 0);
    ticks(3);
    check("R1 idle wave", wave_out, 1);
    check("R1 idle ready", ready, 0);
    check("R1 idle count", rd(), 0);
  endtask

  task automatic t_default_preload();
    pulse_start();
    check("R2 reset preload", rd(), 16'h0002);
    pulse_stop();
  endtask

  task automatic t_counter_basic();
    mode = 1'b1;
    set_preload(16'h0004);
    pulse_start();
    check("R2 preload loaded", rd(), 16'h0004);
    ticks(3);
    check("R8 count at 1", rd(), 16'h0001);
    check("R8 wave before terminal", wave_out, 1);
    check("R8 ready before terminal", ready, 0);
    ticks(1);
    check("R8 count at 0", rd(), 16'h0000);
    check("R8 ready at terminal", ready, 1);
    check("R8 wave at terminal", wave_out, 0);
    ticks(1);
    check("R9 rollover", rd(), 16'hFFFF);
    check("R9 wave stays low", wave_out, 0);
    ticks(2);
    check("R9 continues", rd(), 16'hFFFD);
  endtask

  task automatic t_counter_stop();
    pulse_stop();
    check("R10 wave high on stop", wave_out, 1);
    check("R10 ready cleared", ready, 0);
    check("R10 count held", rd(), 16'hFFFD);
    ticks(3);
    check("R10 count frozen", rd(), 16'hFFFD);
  endtask

  task automatic t_counter_preload();
    pulse_start();
    check("R11 reuse preload", rd(), 16'h0004);
    set_preload(16'h0109);
    check("R11 write ignored by count", rd(), 16'h0004);
    ticks(1);
    check("R11 count from old preload", rd(), 16'h0003);
    pulse_stop();
    pulse_start();
    check("R11 new preload on start", rd(), 16'h0109);
    check("R13 high byte", cnt_hi, 8'h01);
    pulse_stop();
    pulse_start();
    check("R11 preload reused", rd(), 16'h0109);
  endtask

  task automatic t_enable_gate();
    idle(5);
    check("R12 no count without enable", rd(), 16'h0109);
    ticks(1);
    check("R12 one enabled step", rd(), 16'h0108);
    pulse_stop();
  endtask

  task automatic t_timer_basic();
    mode = 1'b0;
    set_preload(16'h0003);
    pulse_start();
    check("R3 wave high after start", wave_out, 1);
    check("R13 readback zero in divider", rd(), 0);
    ticks(2);
    check("R3 wave before half", wave_out, 1);
    ticks(1);
    check("R3 wave toggles low", wave_out, 0);
    check("R4 no ready at half", ready, 0);
    ticks(2);
    check("R3 wave holds low", wave_out, 0);
    ticks(1);
    check("R3 wave back high", wave_out, 1);
    check("R4 ready at full period", ready, 1);
    ticks(3);
    check("R4 ready held", ready, 1);
    check("R3 third half", wave_out, 0);
  endtask

  task automatic t_timer_stop();
    pulse_stop();
    check("R5 ready cleared", ready, 0);
    check("R5 wave untouched", wave_out, 0);
    ticks(3);
    check("R5 still running", wave_out, 1);
    check("R5 ready sets again", ready, 1);
    pulse_stop();
    check("R5 second clear", ready, 0);
  endtask

  task automatic t_timer_preload();
    ticks(1);
    set_preload(16'h0005);
    ticks(1);
    check("R6 current half unchanged", wave_out, 1);
    ticks(1);
    check("R6 old half length", wave_out, 0);
    ticks(4);
    check("R6 new half not yet done", wave_out, 0);
    ticks(1);
    check("R6 new half length", wave_out, 1);
  endtask

  task automatic t_timer_restart();
    ticks(5);
    check("R7 wave low before restart", wave_out, 0);
    ticks(2);
    pulse_start();
    check("R7 restart drives high", wave_out, 1);
    ticks(4);
    check("R7 full fresh half", wave_out, 1);
    ticks(1);
    check("R7 toggle after P", wave_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_preload();
    t_counter_basic();
    t_counter_stop();
    t_counter_preload();
    t_enable_gate();
    t_timer_basic();
    t_timer_stop();
    t_timer_preload();
    t_timer_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule